// File: doc/BRIEF.md
# Clamp and Blanking Pulse Generator

This block derives the combined clamp/blank indication that a display front end needs from timing already cleaned up upstream. It watches a polarity-corrected horizontal sync, a separate vertical sync, a horizontal flyback level and a mode bit. It reports on one two-bit output whether the current clock is active scan, a blanking period or a clamp window. It also issues a one-clock strobe at the moment vertical scan begins.

Three small state machines do the work. The clamp monoflop has states IDLE and PULSE. IDLE goes to PULSE on a falling edge of horizontal sync, and PULSE goes back to IDLE when its down-counter reaches zero. The vertical integrator has states IDLE, COUNT and HOLD. IDLE or COUNT goes to COUNT while composite sync stays high. It goes to HOLD, firing a trigger, on the high sample that completes the integration time. Any low sample returns it to IDLE, and HOLD returns to IDLE when sync drops. When the separate vertical input is selected, the integrator is held in IDLE and rising edges of that input trigger directly. The vertical blanking timer has states SCAN and BLANK. SCAN goes to BLANK on a trigger, loading the delay chosen by the mode bit. BLANK goes to SCAN when its count expires, and that transition raises the scan-start strobe.

Every duration is given in microseconds and converted to clock cycles with the `CLK_HZ` parameter, which must be a whole number of megahertz.

Top module: `clamp_blank_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, the level code is scan (00) and `vscan_start` is low. Reset clears every timer.
- R2: `level` uses 00 for scan, 01 for blank and 10 for clamp. The code 11 never appears.
- R3: A falling edge of `hsync` that is sampled at a clock edge yields the clamp code from the next cycle, for exactly CLK_HZ/1e6 × CLAMP_US cycles.
- R4: Clamp takes priority over blanking. The code is 10 whenever the clamp window is open, even during flyback or vertical blanking.
- R5: Outside a clamp window, `flyback` high gives the blank code combinationally in the same cycle.
- R6: With `vsep_en` = 1, a rising edge of `vsync` sampled at a clock edge starts vertical blanking, which is visible in the cycle after that edge.
- R7: With `vsep_en` = 0, vertical blanking starts at the clock edge where `hsync` has been sampled high for N = CLK_HZ/1e6 × INTEG_US consecutive edges. A high pulse of fewer samples starts no blanking.
- R8: Vertical blanking lasts CLK_HZ/1e6 × VBL_GFX_US cycles when `gfx_mode` = 1 and CLK_HZ/1e6 × VBL_MF_US cycles when it is 0. The mode is taken at the trigger, and later changes do not alter a running interval.
- R9: `vscan_start` is high for exactly one cycle, in the first scan cycle after vertical blanking ends.
- R10: A trigger that arrives while vertical blanking is running is ignored. The interval keeps its original end.
- R11: The unselected vertical source has no effect. `vsync` does nothing when `vsep_en` = 0, and long `hsync` pulses do not start vertical blanking when `vsep_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Polarity-corrected horizontal or composite sync, active high |
| vsync | input | 1 | Separate vertical sync, active high |
| vsep_en | input | 1 | 1 selects `vsync` as the vertical source, 0 integrates `hsync` |
| flyback | input | 1 | Horizontal flyback level, active high |
| gfx_mode | input | 1 | 1 selects the graphics-mode delay, 0 the multi-frequency delay |
| level | output | 2 | Output code: 00 scan, 01 blank, 10 clamp |
| vscan_start | output | 1 | One-cycle strobe at the start of vertical scan |

## Verification
The assertions assume that `hsync` stays low through reset, so the first falling edge they see is a real trailing edge. They also assume that horizontal sync pulses are spaced more than one clamp window apart, so a clamp is never restarted while it is open. The bench meets both conditions. It changes every input once per cycle, away from the clock edge. It keeps every horizontal pulse isolated and waits out each clamp window before starting the next pulse. Pulse widths are swept across the integration threshold, and each vertical interval runs to completion before a fresh trigger is applied.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
    typedef enum logic [1:0] {
        LVL_SCAN  = 2'b00,
        LVL_BLANK = 2'b01,
        LVL_CLAMP = 2'b10
    } lvl_e;

    typedef enum logic {CLP_IDLE, CLP_PULSE} clp_st_e;
    typedef enum logic [1:0] {INT_IDLE, INT_COUNT, INT_HOLD} int_st_e;
    typedef enum logic {VB_SCAN, VB_BLANK} vb_st_e;
endpackage

// File: rtl/cbg_clamp_mono.sv
module cbg_clamp_mono
    import cbg_pkg::*;
#(
    parameter int CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    output logic clamp_on
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

    clp_st_e       st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          hs_d;
    logic          trail;

    // Delayed copy follows the input even in reset, so an edge is only seen when it really occurs.
    always_ff @(posedge clk) hs_d <= hsync;

    assign trail = hs_d & ~hsync;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CLP_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            CLP_IDLE: begin
                if (trail) begin
                    st_nx  = CLP_PULSE;
                    cnt_nx = LOAD;
                end
            end
            CLP_PULSE: begin
                if (trail) begin
                    cnt_nx = LOAD;
                end else if (cnt == '0) begin
                    st_nx = CLP_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: st_nx = CLP_IDLE;
        endcase
    end

    assign clamp_on = (st == CLP_PULSE);
endmodule

// File: rtl/cbg_vsync_integ.sv
module cbg_vsync_integ
    import cbg_pkg::*;
#(
    parameter int CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync,
    input  logic vsync,
    input  logic sel_sep,
    output logic trig
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC);

    int_st_e       st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          vs_d;
    logic          sep_trig;
    logic          cmp_fire;

    always_ff @(posedge clk) vs_d <= vsync;

    assign sep_trig = sel_sep & vsync & ~vs_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= INT_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        cmp_fire = 1'b0;
        unique case (st)
            INT_IDLE, INT_COUNT: begin
                if (sel_sep || !csync) begin
                    st_nx  = INT_IDLE;
                    cnt_nx = '0;
                end else if (cnt + 1'b1 == LAST) begin
                    st_nx    = INT_HOLD;
                    cnt_nx   = '0;
                    cmp_fire = 1'b1;
                end else begin
                    st_nx  = INT_COUNT;
                    cnt_nx = cnt + 1'b1;
                end
            end
            INT_HOLD: begin
                if (sel_sep || !csync) st_nx = INT_IDLE;
            end
            default: st_nx = INT_IDLE;
        endcase
    end

    assign trig = sep_trig | cmp_fire;
endmodule

// File: rtl/cbg_vblank_timer.sv
module cbg_vblank_timer
    import cbg_pkg::*;
#(
    parameter int GFX_CYC = 71875,
    parameter int MF_CYC  = 37500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic gfx_mode,
    output logic blank_on,
    output logic scan_start
);
    localparam int MAXC = (GFX_CYC > MF_CYC) ? GFX_CYC : MF_CYC;
    localparam int W    = $clog2(MAXC + 1);
    localparam logic [W-1:0] LD_GFX = W'(GFX_CYC - 1);
    localparam logic [W-1:0] LD_MF  = W'(MF_CYC - 1);

    vb_st_e       st, st_nx;
    logic [W-1:0] cnt, cnt_nx;
    logic         strobe_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= VB_SCAN;
            cnt        <= '0;
            scan_start <= 1'b0;
        end else begin
            st         <= st_nx;
            cnt        <= cnt_nx;
            scan_start <= strobe_nx;
        end
    end

    always_comb begin
        st_nx     = st;
        cnt_nx    = cnt;
        strobe_nx = 1'b0;
        unique case (st)
            VB_SCAN: begin
                if (trig) begin
                    st_nx  = VB_BLANK;
                    cnt_nx = gfx_mode ? LD_GFX : LD_MF;
                end
            end
            VB_BLANK: begin
                if (cnt == '0) begin
                    st_nx     = VB_SCAN;
                    strobe_nx = 1'b1;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: st_nx = VB_SCAN;
        endcase
    end

    assign blank_on = (st == VB_BLANK);
endmodule

// File: rtl/clamp_blank_gen.sv
module clamp_blank_gen
    import cbg_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int CLAMP_US   = 1,
    parameter int INTEG_US   = 10,
    parameter int VBL_GFX_US = 575,
    parameter int VBL_MF_US  = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync,
    input  logic       vsync,
    input  logic       vsep_en,
    input  logic       flyback,
    input  logic       gfx_mode,
    output logic [1:0] level,
    output logic       vscan_start
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int CLAMP_CYC  = CYC_PER_US * CLAMP_US;
    localparam int INTEG_CYC  = CYC_PER_US * INTEG_US;
    localparam int GFX_CYC    = CYC_PER_US * VBL_GFX_US;
    localparam int MF_CYC     = CYC_PER_US * VBL_MF_US;

    logic clamp_on;
    logic vtrig;
    logic vblank_on;

    cbg_clamp_mono #(.CYC(CLAMP_CYC)) u_clamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .clamp_on (clamp_on)
    );

    cbg_vsync_integ #(.CYC(INTEG_CYC)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .csync   (hsync),
        .vsync   (vsync),
        .sel_sep (vsep_en),
        .trig    (vtrig)
    );

    cbg_vblank_timer #(.GFX_CYC(GFX_CYC), .MF_CYC(MF_CYC)) u_vbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (vtrig),
        .gfx_mode   (gfx_mode),
        .blank_on   (vblank_on),
        .scan_start (vscan_start)
    );

    // Output process: clamp over blank over scan.
    always_comb begin
        if (clamp_on)                    level = LVL_CLAMP;
        else if (flyback || vblank_on)   level = LVL_BLANK;
        else                             level = LVL_SCAN;
    end
endmodule

// File: rtl/cbg_chk.sv
module cbg_chk
    import cbg_pkg::*;
#(
    parameter int CLAMP_CYC = 125
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hsync,
    input logic       flyback,
    input logic [1:0] level,
    input logic       vscan_start
);
    int clamp_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                  clamp_run <= 0;
        else if (level == LVL_CLAMP) clamp_run <= clamp_run + 1;
        else                         clamp_run <= 0;
    end

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level != 2'b11);

    // R3
    clamp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync) |=> level == LVL_CLAMP);

    // R3
    clamp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_run <= CLAMP_CYC);

    // R5
    flyback_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flyback |-> level != LVL_SCAN);

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vscan_start |=> !vscan_start);

    // R9
    strobe_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vscan_start |-> $past(level) != LVL_SCAN);
endmodule

bind clamp_blank_gen cbg_chk #(.CLAMP_CYC(CLK_HZ / 1_000_000 * CLAMP_US)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync       (hsync),
    .flyback     (flyback),
    .level       (level),
    .vscan_start (vscan_start)
);

// File: tb/sim_clamp_blank_gen.sv
module sim_clamp_blank_gen;
    import cbg_pkg::*;

    localparam int CLK_HZ = 4_000_000;
    localparam int CPU    = CLK_HZ / 1_000_000;
    localparam int CLAMP  = CPU * 1;
    localparam int INTEG  = CPU * 10;
    localparam int DGFX   = CPU * 575;
    localparam int DMF    = CPU * 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0, vs = 1'b0, sel = 1'b0, fb = 1'b0, gfx = 1'b0;
    logic [1:0] lvl;
    logic       vss;

    int checks = 0;
    int fails  = 0;

    int t_first, t_last, t_strobes, t_strobe_at, t_fclamp, t_clamps;

    always #4 clk = ~clk;

    clamp_blank_gen #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hs), .vsync(vs), .vsep_en(sel),
        .flyback(fb), .gfx_mode(gfx), .level(lvl), .vscan_start(vss)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic trace(input int hs_w, input int vs_w, input int vs2,
                         input int flip, input int lim);
        t_first = 0; t_last = 0; t_strobes = 0; t_strobe_at = 0;
        t_fclamp = 0; t_clamps = 0;
        if (hs_w > 0) hs = 1'b1;
        if (vs_w > 0) vs = 1'b1;
        for (int t = 1; t <= lim; t++) begin
            step();
            if (lvl != LVL_SCAN) begin
                if (t_first == 0) t_first = t;
                t_last = t;
            end
            if (lvl == LVL_CLAMP) begin
                t_clamps++;
                if (t_fclamp == 0) t_fclamp = t;
            end
            if (vss) begin
                t_strobes++;
                t_strobe_at = t;
            end
            if (t == hs_w) hs = 1'b0;
            if (t == vs_w) vs = 1'b0;
            if (vs2 > 0 && t == vs2) vs = 1'b1;
            if (vs2 > 0 && t == vs2 + 1) vs = 1'b0;
            if (flip > 0 && t == flip) gfx = ~gfx;
        end
        hs = 1'b0;
        vs = 1'b0;
    endtask

    task automatic expect_trace(input string tag, input int first, input int last,
                                input int strobes, input int strobe_at,
                                input int fclamp, input int clamps);
        chk(t_first == first, tag, t_first, first);
        chk(t_last == last, tag, t_last, last);
        chk(t_strobes == strobes, "R9", t_strobes, strobes);
        chk(t_strobe_at == strobe_at, "R9", t_strobe_at, strobe_at);
        chk(t_fclamp == fclamp, "R3", t_fclamp, fclamp);
        chk(t_clamps == clamps, "R3", t_clamps, clamps);
    endtask

    initial begin
        #(8 * 200_000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int dly;
        // R1: reset state
        repeat (3) step();
        chk(lvl == LVL_SCAN, "R1", lvl, LVL_SCAN);
        chk(vss == 1'b0, "R1", vss, 0);
        rst_n = 1'b1;
        step();
        chk(lvl == LVL_SCAN, "R1", lvl, LVL_SCAN);
        chk(lvl != 2'b11, "R2", lvl, 0);

        // R7: composite sweep across the integration threshold, multi-frequency
        sel = 1'b0;
        gfx = 1'b0;
        for (int w = 1; w <= INTEG + 3; w++) begin
            if (w >= INTEG) begin
                trace(w, 0, 0, 0, INTEG + DMF + 20);
                // R4: clamp lands inside the running interval
                expect_trace("R7", INTEG, INTEG + DMF - 1, 1, INTEG + DMF, w + 1, CLAMP);
            end else begin
                trace(w, 0, 0, 0, w + CLAMP + 10);
                expect_trace("R7", w + 1, w + CLAMP, 0, 0, w + 1, CLAMP);
            end
        end

        // R8: composite trigger in graphics mode
        gfx = 1'b1;
        trace(INTEG, 0, 0, 0, INTEG + DGFX + 20);
        expect_trace("R8", INTEG, INTEG + DGFX - 1, 1, INTEG + DGFX, INTEG + 1, CLAMP);

        // R6, R8: separate vertical input, both modes, two widths
        sel = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 2; k++) begin
                gfx = m[0];
                dly = (m == 1) ? DGFX : DMF;
                trace(0, (k == 0) ? 1 : 7, 0, 0, dly + 20);
                expect_trace("R6", 1, dly, 1, dly + 1, 0, 0);
            end
        end

        // R10: second trigger mid-interval and on the last blank cycle
        gfx = 1'b1;
        trace(0, 1, DGFX / 2, 0, DGFX + 20);
        expect_trace("R10", 1, DGFX, 1, DGFX + 1, 0, 0);
        trace(0, 1, DGFX - 1, 0, DGFX + 20);
        expect_trace("R10", 1, DGFX, 1, DGFX + 1, 0, 0);

        // R8: mode flip during the interval keeps the length taken at the trigger
        gfx = 1'b1;
        trace(0, 1, 0, 10, DGFX + 20);
        expect_trace("R8", 1, DGFX, 1, DGFX + 1, 0, 0);
        chk(gfx == 1'b0, "R8", gfx, 0);

        // R11: long hsync in separate mode gives only the clamp
        sel = 1'b1;
        trace(INTEG + 5, 0, 0, 0, INTEG + 20);
        expect_trace("R11", INTEG + 6, INTEG + 5 + CLAMP, 0, 0, INTEG + 6, CLAMP);
        // R11: vsync ignored in composite mode
        sel = 1'b0;
        trace(0, 50, 0, 0, 80);
        expect_trace("R11", 0, 0, 0, 0, 0, 0);

        // R5: flyback gives blank combinationally
        fb = 1'b1;
        #1;
        chk(lvl == LVL_BLANK, "R5", lvl, LVL_BLANK);
        fb = 1'b0;
        #1;
        chk(lvl == LVL_SCAN, "R5", lvl, LVL_SCAN);
        // R4: clamp wins over flyback
        hs = 1'b1;
        step();
        hs = 1'b0;
        step();
        fb = 1'b1;
        #1;
        chk(lvl == LVL_CLAMP, "R4", lvl, LVL_CLAMP);
        fb = 1'b0;
        repeat (CLAMP + 4) step();
        chk(lvl == LVL_SCAN, "R3", lvl, LVL_SCAN);

        // R1: reset in the middle of an interval clears it
        sel = 1'b1;
        vs = 1'b1;
        step();
        vs = 1'b0;
        chk(lvl == LVL_BLANK, "R6", lvl, LVL_BLANK);
        repeat (20) step();
        rst_n = 1'b0;
        step();
        chk(lvl == LVL_SCAN, "R1", lvl, LVL_SCAN);
        rst_n = 1'b1;
        step();
        chk(lvl == LVL_SCAN, "R1", lvl, LVL_SCAN);
        chk(vss == 1'b0, "R1", vss, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule